// File: doc/BRIEF.md
# Receive Timeslot Mapper with Per-Slot Conditioning

This block sits on the receive side of one framed serial line. The line is either a 24-slot 1.544 Mb/s frame or a 32-slot 2.048 Mb/s frame. A bit-enable qualifies each serial bit, and a frame-sync pulse marks where a frame begins. Once the block has seen the first sync, it counts bit positions on its own, groups the bits of each 64 kb/s channel into an octet, and then looks the channel up in a per-slot table.

Each table entry holds four fields:
- an enable flag,
- a 5-bit bundle tag,
- a conditioning flag,
- an 8-bit substitute pattern.

Octets from disabled slots are discarded. Octets from enabled slots leave the block with their slot number and bundle tag. When the conditioning flag is set, the octet is replaced by the slot's pattern. Software may split the slots of one line among up to 32 bundles, in any combination.

Table writes go into a staging copy. The staging copy moves into the working copy only when a new frame begins, so every frame is processed under one consistent configuration.

Top module: `tsa_port_mapper`

## Requirements
- R1: After reset, `out_valid` stays low until a `frame_sync` has been sampled with `bit_en` high, whatever data arrives before that.
- R2: With `e1_mode`=1 a frame is 256 bit positions. The bit sampled with sync is the MSB of slot 0. Slot k is bit positions 8k..8k+7, received MSB first, and is reported with `out_ts`=k.
- R3: With `e1_mode`=0 a frame is 193 bit positions. Position 0, the sync bit, is a framing bit that is discarded. Slot k (0..23) is positions 1+8k..8+8k, MSB first.
- R4: Without further sync pulses, the position counter wraps at the frame length and the next frame stays aligned.
- R5: An octet from a slot whose enable flag is 0 produces no `out_valid`.
- R6: An octet from an enabled slot is output with `out_bid` equal to that slot's bundle tag.
- R7: When a slot's conditioning flag is 1, `out_octet` equals the slot's pattern instead of the line data, and `out_ts` and `out_bid` are unchanged.
- R8: A table write (`cfg_we` with `cfg_ts` as the slot index) does not change any octet of the frame in progress. It applies from the next frame start.
- R9: A sync pulse arriving in the middle of a frame makes that bit position 0 of a new frame. Partially assembled octets are discarded.
- R10: `frame_sync` and `ser_bit` have no effect in cycles where `bit_en` is low.
- R11: `out_valid` is a single-cycle pulse, raised exactly two clock cycles after the `bit_en` cycle that carried the slot's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e1_mode | input | 1 | 1: 32-slot frame, 0: 24-slot frame with framing bit; static while running |
| bit_en | input | 1 | Qualifies `ser_bit` and `frame_sync` |
| frame_sync | input | 1 | Marks frame bit position 0 |
| ser_bit | input | 1 | Serial line data |
| cfg_we | input | 1 | Table write strobe |
| cfg_ts | input | 5 | Slot index to write |
| cfg_en | input | 1 | Slot enable flag |
| cfg_bid | input | 5 | Bundle tag |
| cfg_cond | input | 1 | Conditioning flag |
| cfg_pat | input | 8 | Conditioning pattern |
| out_valid | output | 1 | Octet strobe |
| out_octet | output | 8 | Octet data |
| out_ts | output | 5 | Slot number of the octet |
| out_bid | output | 5 | Bundle tag of the octet |

## Verification
A bit-position counter that is off by even one bit shows up at the ports within the first frame after sync: every octet appears rotated and under the wrong slot number. A counter that wraps at the wrong length shows up in the first frame that starts without a sync. A staging-to-working copy at the wrong moment changes octets of the frame in which the write happened, rather than those of the following frame. The bench therefore writes the table mid-frame and compares both that frame and the next. A fault in slot-enable decoding gives missing or extra strobes in the very frame it affects.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int unsigned NUM_TS   = 32;
    localparam int unsigned T1_TS    = 24;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned BID_W    = 5;
    localparam int unsigned TS_W     = $clog2(NUM_TS);
    localparam int unsigned BIT_W    = $clog2(BYTE_W);
    localparam int unsigned FRAME_E1 = NUM_TS * BYTE_W;
    localparam int unsigned FRAME_T1 = T1_TS * BYTE_W + 1;
    localparam int unsigned CNT_W    = $clog2(FRAME_E1);

    typedef struct packed {
        logic              en;
        logic [BID_W-1:0]  bid;
        logic              cond;
        logic [BYTE_W-1:0] pat;
    } slot_cfg_t;
endpackage

// File: rtl/tsa_framer.sv
module tsa_framer
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e1_mode,
    input  logic              bit_en,
    input  logic              frame_sync,
    input  logic              ser_bit,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic [TS_W-1:0]   byte_ts,
    output logic              frame_start
);
    localparam logic [CNT_W-1:0] LAST_E1 = CNT_W'(FRAME_E1 - 1);
    localparam logic [CNT_W-1:0] LAST_T1 = CNT_W'(FRAME_T1 - 1);

    typedef struct packed {
        logic              locked;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              vld;
        logic [BYTE_W-1:0] octet;
        logic [TS_W-1:0]   ts;
        logic              fstart;
    } fr_state_t;

    fr_state_t        q, d;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] idx;

    assign last = e1_mode ? LAST_E1 : LAST_T1;

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        d.fstart = 1'b0;
        pos      = '0;
        idx      = '0;
        if (bit_en && (frame_sync || q.locked)) begin
            pos      = frame_sync ? '0 : q.cnt;
            d.locked = 1'b1;
            d.cnt    = (pos == last) ? '0 : pos + 1'b1;
            d.fstart = (pos == '0);
            // the 24-slot frame spends position 0 on its framing bit
            if (e1_mode || pos != '0) begin
                idx     = e1_mode ? pos : pos - 1'b1;
                d.shreg = {q.shreg[BYTE_W-2:0], ser_bit};
                if (idx[BIT_W-1:0] == '1) begin
                    d.vld   = 1'b1;
                    d.octet = d.shreg;
                    d.ts    = idx[BIT_W +: TS_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_vld    = q.vld;
    assign byte_data   = q.octet;
    assign byte_ts     = q.ts;
    assign frame_start = q.fstart;
endmodule

// File: rtl/tsa_slot_table.sv
module tsa_slot_table
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [TS_W-1:0]   cfg_ts,
    input  slot_cfg_t         cfg_entry,
    input  logic              frame_start,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [TS_W-1:0]   byte_ts,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_octet,
    output logic [TS_W-1:0]   out_ts,
    output logic [BID_W-1:0]  out_bid
);
    typedef struct packed {
        slot_cfg_t [NUM_TS-1:0] pend;
        slot_cfg_t [NUM_TS-1:0] act;
        logic                   vld;
        logic [BYTE_W-1:0]      octet;
        logic [TS_W-1:0]        ts;
        logic [BID_W-1:0]       bid;
    } tbl_state_t;

    tbl_state_t q, d;
    slot_cfg_t  sel;

    assign sel = q.act[byte_ts];

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        // staging copy becomes live only at a frame start
        if (frame_start) d.act = q.pend;
        if (cfg_we)      d.pend[cfg_ts] = cfg_entry;
        if (byte_vld && sel.en) begin
            d.vld   = 1'b1;
            d.octet = sel.cond ? sel.pat : byte_data;
            d.ts    = byte_ts;
            d.bid   = sel.bid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.vld;
    assign out_octet = q.octet;
    assign out_ts    = q.ts;
    assign out_bid   = q.bid;
endmodule

// File: rtl/tsa_port_mapper.sv
module tsa_port_mapper
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e1_mode,
    input  logic              bit_en,
    input  logic              frame_sync,
    input  logic              ser_bit,
    input  logic              cfg_we,
    input  logic [TS_W-1:0]   cfg_ts,
    input  logic              cfg_en,
    input  logic [BID_W-1:0]  cfg_bid,
    input  logic              cfg_cond,
    input  logic [BYTE_W-1:0] cfg_pat,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_octet,
    output logic [TS_W-1:0]   out_ts,
    output logic [BID_W-1:0]  out_bid
);
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic [TS_W-1:0]   byte_ts;
    logic              frame_start;
    slot_cfg_t         cfg_entry;

    assign cfg_entry = '{en: cfg_en, bid: cfg_bid, cond: cfg_cond, pat: cfg_pat};

    tsa_framer u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .e1_mode     (e1_mode),
        .bit_en      (bit_en),
        .frame_sync  (frame_sync),
        .ser_bit     (ser_bit),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .byte_ts     (byte_ts),
        .frame_start (frame_start)
    );

    tsa_slot_table u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_ts      (cfg_ts),
        .cfg_entry   (cfg_entry),
        .frame_start (frame_start),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .byte_ts     (byte_ts),
        .out_valid   (out_valid),
        .out_octet   (out_octet),
        .out_ts      (out_ts),
        .out_bid     (out_bid)
    );
endmodule

// File: rtl/tsa_port_mapper_chk.sv
module tsa_port_mapper_chk
    import tsa_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            e1_mode,
    input logic            bit_en,
    input logic            frame_sync,
    input logic            out_valid,
    input logic [TS_W-1:0] out_ts
);
    logic seen_sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                   seen_sync_q <= 1'b0;
        else if (bit_en && frame_sync) seen_sync_q <= 1'b1;
    end

    // R1: silent until the first qualified sync
    a_r1_quiet_until_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sync_q |-> !out_valid);

    // R3: the 24-slot frame never reports a slot number above 23
    a_r3_t1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !e1_mode) |-> (out_ts < TS_W'(T1_TS)));

    // R11: a strobe follows a bit-enable cycle by two clocks
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bit_en, 2));

    // R11: strobes last one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

bind tsa_port_mapper tsa_port_mapper_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .e1_mode    (e1_mode),
    .bit_en     (bit_en),
    .frame_sync (frame_sync),
    .out_valid  (out_valid),
    .out_ts     (out_ts)
);

// File: tb/tb_tsa_port_mapper.sv
module tb_tsa_port_mapper;
    import tsa_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, e1_mode, bit_en, frame_sync, ser_bit;
    logic              cfg_we, cfg_en, cfg_cond;
    logic [TS_W-1:0]   cfg_ts;
    logic [BID_W-1:0]  cfg_bid;
    logic [BYTE_W-1:0] cfg_pat;
    logic              out_valid;
    logic [BYTE_W-1:0] out_octet;
    logic [TS_W-1:0]   out_ts;
    logic [BID_W-1:0]  out_bid;

    tsa_port_mapper dut (.*);

    typedef struct {
        logic [BYTE_W-1:0] b;
        logic [TS_W-1:0]   ts;
        logic [BID_W-1:0]  bid;
        string             tag;
    } exp_t;

    exp_t      sbq[$];
    exp_t      mon_e;
    slot_cfg_t m_pend [NUM_TS];
    slot_cfg_t m_act  [NUM_TS];
    bit        m_e1;
    int        n_chk = 0, n_fail = 0, n_valid = 0;
    logic [1:0] be_hist = 2'b00;
    slot_cfg_t none_cfg = '0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) be_hist <= {be_hist[0], bit_en};

    // monitor: pops one expected item per strobe
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_valid++;
            check(be_hist[1] == 1'b1, "R11", "strobe not two cycles after bit enable", int'(be_hist[1]), 1);
            if (sbq.size() == 0) begin
                check(1'b0, "R5", "unexpected output for slot", int'(out_ts), 0);
            end else begin
                mon_e = sbq.pop_front();
                check(out_octet == mon_e.b, mon_e.tag, "octet", int'(out_octet), int'(mon_e.b));
                check(out_ts == mon_e.ts, m_e1 ? "R2" : "R3", "slot number", int'(out_ts), int'(mon_e.ts));
                check(out_bid == mon_e.bid, "R6", "bundle tag", int'(out_bid), int'(mon_e.bid));
            end
        end
    end

    task automatic cyc(bit be, bit fs, bit sb);
        @(negedge clk);
        bit_en = be; frame_sync = fs; ser_bit = sb; cfg_we = 1'b0;
    endtask

    task automatic put_cfg(int s, slot_cfg_t c);
        cfg_we = 1'b1; cfg_ts = TS_W'(s);
        cfg_en = c.en; cfg_bid = c.bid; cfg_cond = c.cond; cfg_pat = c.pat;
        m_pend[s] = c;
    endtask

    task automatic write_cfg(int s, slot_cfg_t c);
        @(negedge clk);
        bit_en = 1'b0; frame_sync = 1'b0;
        put_cfg(s, c);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drives nbits positions starting at frame position 0
    task automatic send_frame(int nbits, bit sync, bit gaps, int mw_pos, int mw_ts,
                              slot_cfg_t mw_cfg, string tag);
        logic [BYTE_W-1:0] data [NUM_TS];
        int nslots, off, idx;
        bit b;
        nslots = m_e1 ? NUM_TS : T1_TS;
        off    = m_e1 ? 0 : 1;
        for (int s = 0; s < NUM_TS; s++) data[s] = BYTE_W'($urandom);
        for (int s = 0; s < NUM_TS; s++) m_act[s] = m_pend[s];
        for (int s = 0; s < nslots; s++) begin
            if (off + 8 * s + 7 < nbits && m_act[s].en)
                sbq.push_back('{m_act[s].cond ? m_act[s].pat : data[s], TS_W'(s),
                                m_act[s].bid, m_act[s].cond ? "R7" : tag});
        end
        for (int pos = 0; pos < nbits; pos++) begin
            if (gaps) cyc(1'b0, 1'b1, 1'($urandom));   // R10: ignored cycle
            if (off == 1 && pos == 0) b = 1'($urandom);
            else begin
                idx = pos - off;
                b = data[idx / 8][7 - (idx % 8)];
            end
            @(negedge clk);
            bit_en = 1'b1; frame_sync = sync && (pos == 0); ser_bit = b;
            if (pos == mw_pos) put_cfg(mw_ts, mw_cfg);
            else cfg_we = 1'b0;
        end
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        check(sbq.size() == 0, tag, "expected octets not produced", sbq.size(), 0);
        sbq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v0;
        slot_cfg_t c;
        rst_n = 1'b0; e1_mode = 1'b1; m_e1 = 1'b1;
        bit_en = 1'b0; frame_sync = 1'b0; ser_bit = 1'b0;
        cfg_we = 1'b0; cfg_ts = '0; cfg_en = 1'b0; cfg_bid = '0; cfg_cond = 1'b0; cfg_pat = '0;
        for (int s = 0; s < NUM_TS; s++) begin m_pend[s] = '0; m_act[s] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        for (int s = 0; s < NUM_TS; s++) begin
            c.en   = (s % 3 != 2);
            c.bid  = BID_W'((s * 5) % 32);
            c.cond = (s % 5 == 1);
            c.pat  = BYTE_W'(8'h3C ^ s);
            write_cfg(s, c);
        end

        // R1: line data with no sync yields nothing
        v0 = n_valid;
        for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 1'($urandom));
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        check(n_valid == v0, "R1", "strobes before first sync", n_valid - v0, 0);

        send_frame(256, 1'b1, 1'b0, -1, 0, none_cfg, "R2");
        send_frame(256, 1'b0, 1'b0, -1, 0, none_cfg, "R4");
        send_frame(256, 1'b0, 1'b1, -1, 0, none_cfg, "R10");

        // R8: write slot 30 and slot 0 mid-frame; only the next frame sees them
        c = '{en: 1'b1, bid: 5'd9, cond: 1'b0, pat: 8'h00};
        send_frame(256, 1'b0, 1'b0, 40, 30, c, "R8");
        c = '{en: 1'b1, bid: 5'd21, cond: 1'b1, pat: 8'hE7};
        send_frame(256, 1'b0, 1'b0, 200, 0, c, "R8");
        send_frame(256, 1'b0, 1'b0, -1, 0, none_cfg, "R8");

        // R9: resync in the middle of a frame
        send_frame(45, 1'b0, 1'b0, -1, 0, none_cfg, "R9");
        send_frame(256, 1'b1, 1'b0, -1, 0, none_cfg, "R9");

        // R3: 24-slot framing
        e1_mode = 1'b0; m_e1 = 1'b0;
        send_frame(193, 1'b1, 1'b0, -1, 0, none_cfg, "R3");
        send_frame(193, 1'b0, 1'b1, -1, 0, none_cfg, "R3");
        send_frame(100, 1'b0, 1'b0, -1, 0, none_cfg, "R9");
        send_frame(193, 1'b1, 1'b0, -1, 0, none_cfg, "R9");

        // R5: every slot disabled
        for (int s = 0; s < NUM_TS; s++) begin
            c = m_pend[s]; c.en = 1'b0; write_cfg(s, c);
        end
        v0 = n_valid;
        send_frame(193, 1'b0, 1'b0, -1, 0, none_cfg, "R5");
        check(n_valid == v0, "R5", "strobes with all slots disabled", n_valid - v0, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule